// File: doc/BRIEF.md
# Nibble Register Bank with Conditional Skip Flag

This block is the register and flag section of a small 4-bit processor datapath. It keeps an accumulator, a scratch accumulator, a file-address register and a digit-address register, each address register paired with a shadow copy. It also keeps a carry flag and a status flag. Each cycle a decoder outside the block presents decoded micro-operations. These load an ALU result, swap an address register with its shadow, rotate the accumulator through carry, force or clear carry, step the digit register, or capture a status result. The ALU result and overflow come in as plain inputs.

The status flag decides the fate of conditional page-load, branch and call instructions. While a conditional instruction is decoded, the block reports combinationally whether to execute it or skip it. A skip re-arms the status flag to 1 on the same clock edge, so only one instruction is suppressed. The two address pairs are also presented joined as 8-bit RAM addresses, shadow in the upper nibble.

Top module: `nibble_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, scratch, file, file shadow, digit and digit shadow registers and the carry flag to 0, and sets the status flag to 1.
- R2: With `ld_acc` high, the accumulator takes `alu_res` and the carry flag takes `alu_ovf` at the next edge; this overrides rotate, carry force and carry clear.
- R3: `ld_scr`, `ld_file` and `ld_dig` each write `alu_res` into the scratch, file and digit register respectively; a register without a write keeps its value.
- R4: When neither a load of the accumulator nor a rotate is requested, `c_force` sets carry to 1, otherwise `c_clear` clears it to 0; force wins over clear.
- R5: `rot_go` rotates the 5-bit ring {carry, accumulator} one place. With `rot_dir_l`=1 the new accumulator is {acc[W-2:0], carry} and the new carry is acc[W-1]. With `rot_dir_l`=0 the new accumulator is {carry, acc[W-1:1]} and the new carry is acc[0].
- R6: `swap_file` exchanges the file register and its shadow in one edge and takes priority over `ld_file`.
- R7: `swap_dig` exchanges the digit register and its shadow in one edge and takes priority over both `ld_dig` and stepping.
- R8: With no swap or load of the digit register, `dig_step` changes it by one modulo 2^W: down when `dig_down`=1, up when 0.
- R9: `st_upd` loads `st_val` into the status flag at the next edge, unless R11 applies.
- R10: `skip` equals `cond_op` AND NOT status, and `exec` equals `cond_op` AND status, both combinational in the same cycle.
- R11: A skipped conditional instruction (`cond_op` high while status is 0) sets status to 1 at that edge, overriding `st_upd`.
- R12: `file_addr` is {file shadow, file} and `dig_addr` is {digit shadow, digit}, shadow in the upper W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_res | input | W | ALU result nibble |
| alu_ovf | input | 1 | ALU overflow |
| ld_acc | input | 1 | Load accumulator and carry |
| ld_scr | input | 1 | Load scratch register |
| ld_file | input | 1 | Load file register |
| ld_dig | input | 1 | Load digit register |
| swap_file | input | 1 | Exchange file register and shadow |
| swap_dig | input | 1 | Exchange digit register and shadow |
| rot_go | input | 1 | Rotate {carry, accumulator} |
| rot_dir_l | input | 1 | Rotate direction, 1 = left |
| c_force | input | 1 | Set carry |
| c_clear | input | 1 | Clear carry |
| dig_step | input | 1 | Step digit register |
| dig_down | input | 1 | Step direction, 1 = decrement |
| st_upd | input | 1 | Capture status value |
| st_val | input | 1 | Status value to capture |
| cond_op | input | 1 | Conditional instruction decoded |
| acc | output | W | Accumulator |
| scr | output | W | Scratch register |
| file_r | output | W | File register |
| file_sh | output | W | File shadow register |
| dig_r | output | W | Digit register |
| dig_sh | output | W | Digit shadow register |
| carry | output | 1 | Carry flag |
| status | output | 1 | Status flag |
| skip | output | 1 | Suppress the conditional instruction |
| exec | output | 1 | Execute the conditional instruction |
| file_addr | output | 2W | {file shadow, file} |
| dig_addr | output | 2W | {digit shadow, digit} |

## Verification
The bench builds the block with the default nibble width W=4. At that width, random loads, steps and rotates cover every register value in a few hundred cycles. They also reach the digit wrap from 15 to 0 and back, and the carry bits moving out at both ends of the ring. Directed sequences line up the overlaps in one cycle: a swap against a load and a step, a skip against a status capture, and a load of the accumulator against a rotate.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        CSRC_KEEP  = 2'd0,
        CSRC_ALU   = 2'd1,
        CSRC_RING  = 2'd2,
        CSRC_FIXED = 2'd3
    } csrc_e;

endpackage

// File: rtl/nrf_accum.sv
module nrf_accum #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] alu_res,
    input  logic         alu_ovf,
    input  logic         ld_acc,
    input  logic         rot_go,
    input  logic         rot_dir_l,
    input  logic         c_force,
    input  logic         c_clear,
    output logic [W-1:0] acc_q,
    output logic         carry_q
);
    import nrf_pkg::*;

    typedef struct packed {
        logic [W-1:0] acc;
        logic         c;
    } acc_state_t;

    acc_state_t cur_q, nxt_d;
    csrc_e      csrc_d;
    logic       fixed_d;

    // carry source selection: ALU load > rotate > force > clear
    always_comb begin
        csrc_d  = CSRC_KEEP;
        fixed_d = 1'b0;
        if (ld_acc) begin
            csrc_d = CSRC_ALU;
        end else if (rot_go) begin
            csrc_d = CSRC_RING;
        end else if (c_force) begin
            csrc_d  = CSRC_FIXED;
            fixed_d = 1'b1;
        end else if (c_clear) begin
            csrc_d  = CSRC_FIXED;
            fixed_d = 1'b0;
        end
    end

    always_comb begin
        nxt_d = cur_q;
        unique case (csrc_d)
            CSRC_ALU: begin
                nxt_d.acc = alu_res;
                nxt_d.c   = alu_ovf;
            end
            CSRC_RING: begin
                if (rot_dir_l) begin
                    nxt_d.acc = {cur_q.acc[W-2:0], cur_q.c};
                    nxt_d.c   = cur_q.acc[W-1];
                end else begin
                    nxt_d.acc = {cur_q.c, cur_q.acc[W-1:1]};
                    nxt_d.c   = cur_q.acc[0];
                end
            end
            CSRC_FIXED: nxt_d.c = fixed_d;
            default:    nxt_d = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign acc_q   = cur_q.acc;
    assign carry_q = cur_q.c;

    AST_ACC_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_acc |=> (acc_q == $past(alu_res)) && (carry_q == $past(alu_ovf))); // R2
    AST_RING_LEFT: assert property (@(posedge clk) disable iff (rst)
        (rot_go && rot_dir_l && !ld_acc) |=>
            (acc_q == {$past(acc_q[W-2:0]), $past(carry_q)}) && (carry_q == $past(acc_q[W-1]))); // R5
    AST_RING_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (rot_go && !rot_dir_l && !ld_acc) |=>
            (acc_q == {$past(carry_q), $past(acc_q[W-1:1])}) && (carry_q == $past(acc_q[0]))); // R5
    AST_CARRY_FORCE: assert property (@(posedge clk) disable iff (rst)
        (c_force && !ld_acc && !rot_go) |=> carry_q); // R4
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (c_clear && !c_force && !ld_acc && !rot_go) |=> !carry_q); // R4

endmodule

// File: rtl/nrf_pair.sv
module nrf_pair #(
    parameter int W       = 4,
    parameter bit STEP_EN = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   ld_val,
    input  logic           ld,
    input  logic           swap,
    input  nrf_pkg::step_e step,
    output logic [W-1:0]   main_q,
    output logic [W-1:0]   shadow_q
);
    import nrf_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] main;
        logic [W-1:0] shadow;
    } pair_state_t;

    pair_state_t  cur_q, nxt_d;
    logic [W-1:0] stepped;

    generate
        if (STEP_EN) begin : g_step
            always_comb begin
                unique case (step)
                    STEP_UP:   stepped = cur_q.main + ONE;
                    STEP_DOWN: stepped = cur_q.main - ONE;
                    default:   stepped = cur_q.main;
                endcase
            end
        end else begin : g_nostep
            logic [1:0] step_unused;
            assign step_unused = step;
            assign stepped     = cur_q.main;
        end
    endgenerate

    // priority: exchange > load > step
    always_comb begin
        nxt_d = cur_q;
        if (swap) begin
            nxt_d.main   = cur_q.shadow;
            nxt_d.shadow = cur_q.main;
        end else if (ld) begin
            nxt_d.main = ld_val;
        end else begin
            nxt_d.main = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign main_q   = cur_q.main;
    assign shadow_q = cur_q.shadow;

    AST_PAIR_SWAP: assert property (@(posedge clk) disable iff (rst)
        swap |=> (main_q == $past(shadow_q)) && (shadow_q == $past(main_q))); // R6
    AST_PAIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ld && !swap) |=> (main_q == $past(ld_val)) && $stable(shadow_q)); // R3
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !swap |=> $stable(shadow_q)); // R7

endmodule

// File: rtl/nrf_status.sv
module nrf_status (
    input  logic clk,
    input  logic rst,
    input  logic st_upd,
    input  logic st_val,
    input  logic cond_op,
    output logic status_q,
    output logic skip,
    output logic exec
);
    typedef struct packed {
        logic s;
    } st_state_t;

    st_state_t cur_q, nxt_d;

    assign skip = cond_op & ~cur_q.s;
    assign exec = cond_op & cur_q.s;

    // a skip re-arms the flag and wins over a capture
    always_comb begin
        nxt_d = cur_q;
        if (skip) begin
            nxt_d.s = 1'b1;
        end else if (st_upd) begin
            nxt_d.s = st_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{s: 1'b1};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign status_q = cur_q.s;

    AST_SKIP_REARM: assert property (@(posedge clk) disable iff (rst)
        (cond_op && !status_q) |=> status_q); // R11
    AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (st_upd && !(cond_op && !status_q)) |=> (status_q == $past(st_val))); // R9
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!st_upd && !cond_op) |=> $stable(status_q)); // R9

endmodule

// File: rtl/nibble_regfile.sv
module nibble_regfile #(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   alu_res,
    input  logic           alu_ovf,
    input  logic           ld_acc,
    input  logic           ld_scr,
    input  logic           ld_file,
    input  logic           ld_dig,
    input  logic           swap_file,
    input  logic           swap_dig,
    input  logic           rot_go,
    input  logic           rot_dir_l,
    input  logic           c_force,
    input  logic           c_clear,
    input  logic           dig_step,
    input  logic           dig_down,
    input  logic           st_upd,
    input  logic           st_val,
    input  logic           cond_op,
    output logic [W-1:0]   acc,
    output logic [W-1:0]   scr,
    output logic [W-1:0]   file_r,
    output logic [W-1:0]   file_sh,
    output logic [W-1:0]   dig_r,
    output logic [W-1:0]   dig_sh,
    output logic           carry,
    output logic           status,
    output logic           skip,
    output logic           exec,
    output logic [2*W-1:0] file_addr,
    output logic [2*W-1:0] dig_addr
);
    import nrf_pkg::*;

    step_e        dig_step_d;
    logic [W-1:0] scr_d, scr_q;

    always_comb begin
        if (!dig_step) begin
            dig_step_d = STEP_HOLD;
        end else if (dig_down) begin
            dig_step_d = STEP_DOWN;
        end else begin
            dig_step_d = STEP_UP;
        end
    end

    always_comb begin
        scr_d = scr_q;
        if (ld_scr) begin
            scr_d = alu_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scr_q <= '0;
        end else begin
            scr_q <= scr_d;
        end
    end

    nrf_accum #(.W(W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .alu_res   (alu_res),
        .alu_ovf   (alu_ovf),
        .ld_acc    (ld_acc),
        .rot_go    (rot_go),
        .rot_dir_l (rot_dir_l),
        .c_force   (c_force),
        .c_clear   (c_clear),
        .acc_q     (acc),
        .carry_q   (carry)
    );

    nrf_pair #(.W(W), .STEP_EN(1'b0)) u_file (
        .clk      (clk),
        .rst      (rst),
        .ld_val   (alu_res),
        .ld       (ld_file),
        .swap     (swap_file),
        .step     (STEP_HOLD),
        .main_q   (file_r),
        .shadow_q (file_sh)
    );

    nrf_pair #(.W(W), .STEP_EN(1'b1)) u_dig (
        .clk      (clk),
        .rst      (rst),
        .ld_val   (alu_res),
        .ld       (ld_dig),
        .swap     (swap_dig),
        .step     (dig_step_d),
        .main_q   (dig_r),
        .shadow_q (dig_sh)
    );

    nrf_status u_status (
        .clk      (clk),
        .rst      (rst),
        .st_upd   (st_upd),
        .st_val   (st_val),
        .cond_op  (cond_op),
        .status_q (status),
        .skip     (skip),
        .exec     (exec)
    );

    assign scr       = scr_q;
    assign file_addr = {file_sh, file_r};
    assign dig_addr  = {dig_sh, dig_r};

    AST_DIG_STEP: assert property (@(posedge clk) disable iff (rst)
        (dig_step && !dig_down && !ld_dig && !swap_dig) |=> (dig_r == $past(dig_r) + W'(1))); // R8
    AST_SCR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_scr |=> $stable(scr)); // R3
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (acc == '0) && !carry && status && (dig_r == '0) && (file_sh == '0)); // R1

endmodule

// File: tb/nibble_regfile_bench.sv
`timescale 1ns/1ps
module nibble_regfile_bench;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst;
    logic [W-1:0] alu_res;
    logic alu_ovf, ld_acc, ld_scr, ld_file, ld_dig, swap_file, swap_dig;
    logic rot_go, rot_dir_l, c_force, c_clear, dig_step, dig_down;
    logic st_upd, st_val, cond_op;
    logic [W-1:0] acc, scr, file_r, file_sh, dig_r, dig_sh;
    logic carry, status, skip, exec;
    logic [2*W-1:0] file_addr, dig_addr;

    always #2.5 clk = ~clk;

    nibble_regfile #(.W(W)) u_nibble_regfile (
        .clk(clk), .rst(rst), .alu_res(alu_res), .alu_ovf(alu_ovf),
        .ld_acc(ld_acc), .ld_scr(ld_scr), .ld_file(ld_file), .ld_dig(ld_dig),
        .swap_file(swap_file), .swap_dig(swap_dig), .rot_go(rot_go),
        .rot_dir_l(rot_dir_l), .c_force(c_force), .c_clear(c_clear),
        .dig_step(dig_step), .dig_down(dig_down), .st_upd(st_upd),
        .st_val(st_val), .cond_op(cond_op), .acc(acc), .scr(scr),
        .file_r(file_r), .file_sh(file_sh), .dig_r(dig_r), .dig_sh(dig_sh),
        .carry(carry), .status(status), .skip(skip), .exec(exec),
        .file_addr(file_addr), .dig_addr(dig_addr)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model state
    logic [W-1:0] m_a, m_b, m_x, m_sx, m_y, m_sy;
    logic m_c, m_s;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ring_acc(input logic [W-1:0] a, input logic c, input logic left);
        return left ? {a[W-2:0], c} : {c, a[W-1:1]};
    endfunction

    function automatic logic ring_c(input logic [W-1:0] a, input logic left);
        return left ? a[W-1] : a[0];
    endfunction

    task automatic idle();
        alu_res = '0; alu_ovf = 0; ld_acc = 0; ld_scr = 0; ld_file = 0; ld_dig = 0;
        swap_file = 0; swap_dig = 0; rot_go = 0; rot_dir_l = 0; c_force = 0;
        c_clear = 0; dig_step = 0; dig_down = 0; st_upd = 0; st_val = 0; cond_op = 0;
    endtask

    task automatic model_update();
        logic [W-1:0] t;
        if (rst) begin
            m_a = '0; m_b = '0; m_x = '0; m_sx = '0; m_y = '0; m_sy = '0; m_c = 0; m_s = 1;
            return;
        end
        if (ld_acc) begin m_c = alu_ovf; m_a = alu_res; end
        else if (rot_go) begin
            t = ring_acc(m_a, m_c, rot_dir_l); m_c = ring_c(m_a, rot_dir_l); m_a = t;
        end
        else if (c_force) m_c = 1'b1;
        else if (c_clear) m_c = 1'b0;
        if (ld_scr) m_b = alu_res;
        if (swap_file) begin t = m_x; m_x = m_sx; m_sx = t; end
        else if (ld_file) m_x = alu_res;
        if (swap_dig) begin t = m_y; m_y = m_sy; m_sy = t; end
        else if (ld_dig) m_y = alu_res;
        else if (dig_step) m_y = dig_down ? m_y - W'(1) : m_y + W'(1);
        if (cond_op && !m_s) m_s = 1'b1;
        else if (st_upd) m_s = st_val;
    endtask

    task automatic check_regs();
        chk("R2 R5 acc", acc, m_a);
        chk("R2 R4 carry", carry, m_c);
        chk("R3 scr", scr, m_b);
        chk("R3 R6 file", file_r, m_x);
        chk("R6 file shadow", file_sh, m_sx);
        chk("R7 R8 digit", dig_r, m_y);
        chk("R7 digit shadow", dig_sh, m_sy);
        chk("R9 R11 status", status, m_s);
        chk("R12 file_addr", file_addr, {m_sx, m_x});
        chk("R12 dig_addr", dig_addr, {m_sy, m_y});
    endtask

    // inputs are set at a falling edge before calling
    task automatic cycle();
        #1;
        chk("R10 skip", skip, cond_op & ~m_s);
        chk("R10 exec", exec, cond_op & m_s);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_regs();
    endtask

    task automatic rand_ops();
        alu_res   = W'($urandom);
        alu_ovf   = 1'($urandom);
        ld_acc    = ($urandom % 4) == 0;
        ld_scr    = ($urandom % 4) == 0;
        ld_file   = ($urandom % 4) == 0;
        ld_dig    = ($urandom % 5) == 0;
        swap_file = ($urandom % 5) == 0;
        swap_dig  = ($urandom % 5) == 0;
        rot_go    = ($urandom % 3) == 0;
        rot_dir_l = 1'($urandom);
        c_force   = ($urandom % 5) == 0;
        c_clear   = ($urandom % 5) == 0;
        dig_step  = ($urandom % 2) == 0;
        dig_down  = 1'($urandom);
        st_upd    = ($urandom % 3) == 0;
        st_val    = 1'($urandom);
        cond_op   = ($urandom % 3) == 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        rst = 1'b1;
        @(negedge clk);
        rand_ops();
        @(posedge clk); model_update();
        @(negedge clk);
        idle(); rst = 1'b0;
        // R1: reset state even with ops active at the reset edge
        check_regs();
        chk("R1 status after reset", status, 1);

        // R5 corner: left rotate moves MSB into carry
        alu_res = 4'b1000; alu_ovf = 0; ld_acc = 1; cycle(); idle();
        rot_go = 1; rot_dir_l = 1; cycle();
        chk("R5 left acc", acc, 0); chk("R5 left carry", carry, 1);
        rot_dir_l = 0; cycle();
        chk("R5 right acc", acc, 4'b1000); chk("R5 right carry", carry, 0);
        // R2 load wins over rotate and force
        rot_go = 1; c_force = 1; ld_acc = 1; alu_res = 4'd5; alu_ovf = 0; cycle(); idle();
        chk("R2 load over rotate", acc, 5); chk("R2 ovf into carry", carry, 0);
        // R4 force beats clear
        c_force = 1; c_clear = 1; cycle(); idle();
        chk("R4 force over clear", carry, 1);
        c_clear = 1; cycle(); idle();
        chk("R4 clear", carry, 0);

        // R8 wrap both ways
        alu_res = 4'hF; ld_dig = 1; cycle(); idle();
        dig_step = 1; cycle();
        chk("R8 inc wrap", dig_r, 0);
        dig_down = 1; cycle(); idle();
        chk("R8 dec wrap", dig_r, 15);
        // R7 swap beats load and step
        swap_dig = 1; ld_dig = 1; dig_step = 1; alu_res = 4'd3; cycle(); idle();
        chk("R7 swap priority digit", dig_r, 0);
        chk("R7 swap priority shadow", dig_sh, 15);
        // R6 swap beats load
        alu_res = 4'd9; ld_file = 1; cycle(); idle();
        swap_file = 1; ld_file = 1; alu_res = 4'd2; cycle(); idle();
        chk("R6 swap file", file_sh, 9); chk("R6 swap file main", file_r, 0);

        // R11 skip re-arms and overrides capture
        st_upd = 1; st_val = 0; cycle(); idle();
        chk("R9 capture zero", status, 0);
        cond_op = 1; st_upd = 1; st_val = 0; cycle(); idle();
        chk("R11 rearm over capture", status, 1);
        cond_op = 1; cycle(); idle();
        chk("R10 exec keeps status", status, 1);

        // random phase
        for (int i = 0; i < 600; i++) begin
            rand_ops();
            cycle();
        end
        idle();

        // mid-run reset
        rand_ops(); rst = 1'b1; cycle(); rst = 1'b0; idle();
        chk("R1 mid-run reset acc", acc, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule